// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This unit resolves data and control hazards for a five-stage in-order pipeline (fetch, decode with register read, execute or address calculation, memory access, write back). The decode stage presents each instruction's source specifiers, chosen destination and control bits. The unit keeps its own copy of the hazard-relevant fields as they move through the execute, memory and write-back latches. From that copy it drives the bypass selects for both ALU operands, detects a load whose result the next instruction needs, and clears the wrongly fetched instruction when decode resolves a branch as taken.

A load-use hazard freezes the program counter and the fetch/decode latch for one cycle. During that cycle it inserts a bubble into execute, so the dependent instruction is decoded again one cycle later. A taken branch does not stop fetch. It raises a flush that turns the fetched instruction into a no-op. The register file writes in the first half of the cycle and reads in the second, so a producer three slots ahead needs no bypass. The datapath, the register file and the memories lie outside this block.

Top module: `hazard_ctrl_unit`

## Requirements
- R1: `fwd_a` is 2'b10 when the instruction in the memory stage has its register-write bit set, a nonzero destination, and a destination equal to the `rs` of the instruction in execute.
- R2: `fwd_b` is 2'b10 under the same conditions, with the `rt` of the instruction in execute in place of `rs`.
- R3: When only the write-back stage meets those conditions for an operand, that select is 2'b01.
- R4: When both the memory stage and the write-back stage match an operand, the select is 2'b10, so the newer result wins.
- R5: A select is 2'b00 (register file) when the matching producer writes register 0 or has its register-write bit clear.
- R6: A load-use stall occurs when the instruction in execute has its load bit set and a nonzero destination equal to the decode `rs` or `rt`. In that same cycle `pc_we` and `ifid_we` are 0 and `idex_bubble` is 1. A load that writes register 0, or that is followed by an independent instruction, does not stall.
- R7: The bubble enters execute in place of the held instruction and never acts as a producer. A stall therefore lasts exactly one cycle. The repeated instruction then reaches execute while the load is in write-back and receives select 2'b01.
- R8: `if_flush` is 1 in the cycle the decode instruction has its branch bit set and the compare-equal input is 1. `pc_we` stays 1. A branch whose compare is unequal does not flush.
- R9: A branch held in decode by a load-use stall does not flush in the stall cycle. It flushes in the following cycle if it is still taken.
- R10: A producer three instructions ahead of a consumer gives select 2'b00, because the split-cycle register file already supplies the value.
- R11: While reset is asserted and decode is idle, both selects are 2'b00, `pc_we` and `ifid_we` are 1, and `idex_bubble` and `if_flush` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs | input | ADDR_W | First source register of the decode instruction |
| id_rt | input | ADDR_W | Second source register of the decode instruction |
| id_dst | input | ADDR_W | Destination register chosen in decode |
| id_regwrite | input | 1 | Decode instruction writes a register |
| id_memread | input | 1 | Decode instruction is a load |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_equal | input | 1 | Decode-stage compare found the branch taken |
| fwd_a | output | 2 | Operand A source: 00 register file, 10 memory stage, 01 write-back stage |
| fwd_b | output | 2 | Operand B source, same encoding |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode latch write enable |
| idex_bubble | output | 1 | Replace the decode instruction entering execute with a no-op |
| if_flush | output | 1 | Clear the instruction just fetched |

## Verification
The hardest case to reach is a branch that depends on a load and so sits in decode during a stall. Stall and flush then compete in one cycle, and the flush has to appear in the next cycle, after the bubble has entered execute. The stimulus issues a load and then a taken branch that reads the loaded register. The bench keeps the branch in decode for as long as its own model predicts a stall. That reproduces the held latch and checks each of the two cycles separately. The same hold mechanism is used after an ordinary load-use stall, to confirm that the repeated instruction picks up the write-back bypass.

// File: rtl/hcu_pkg.sv
package hcu_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned HCU_NUM_OPND = 2;

endpackage

// File: rtl/hcu_stage_track.sv
module hcu_stage_track #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] id_rs,
  input  logic [ADDR_W-1:0] id_rt,
  input  logic [ADDR_W-1:0] id_dst,
  input  logic              id_regwrite,
  input  logic              id_memread,
  input  logic              insert_bubble,
  output logic [ADDR_W-1:0] ex_rs,
  output logic [ADDR_W-1:0] ex_rt,
  output logic [ADDR_W-1:0] ex_dst,
  output logic              ex_regwrite,
  output logic              ex_memread,
  output logic [ADDR_W-1:0] mem_dst,
  output logic              mem_regwrite,
  output logic [ADDR_W-1:0] wb_dst,
  output logic              wb_regwrite
);

  logic [ADDR_W-1:0] ex_rs_d, ex_rt_d, ex_dst_d, mem_dst_d, wb_dst_d;
  logic              ex_rw_d, ex_mr_d, mem_rw_d, wb_rw_d;
  logic              adv_en;

  // the tracked latches advance every cycle; a stall only changes what enters execute
  assign adv_en = 1'b1;

  always_comb begin
    ex_rs_d   = id_rs;
    ex_rt_d   = id_rt;
    ex_dst_d  = id_dst;
    ex_rw_d   = id_regwrite;
    ex_mr_d   = id_memread;
    if (insert_bubble) begin
      ex_rs_d  = '0;
      ex_rt_d  = '0;
      ex_dst_d = '0;
      ex_rw_d  = 1'b0;
      ex_mr_d  = 1'b0;
    end
    mem_dst_d = ex_dst;
    mem_rw_d  = ex_regwrite;
    wb_dst_d  = mem_dst;
    wb_rw_d   = mem_regwrite;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_rs        <= '0;
      ex_rt        <= '0;
      ex_dst       <= '0;
      ex_regwrite  <= 1'b0;
      ex_memread   <= 1'b0;
      mem_dst      <= '0;
      mem_regwrite <= 1'b0;
      wb_dst       <= '0;
      wb_regwrite  <= 1'b0;
    end else if (adv_en) begin
      ex_rs        <= ex_rs_d;
      ex_rt        <= ex_rt_d;
      ex_dst       <= ex_dst_d;
      ex_regwrite  <= ex_rw_d;
      ex_memread   <= ex_mr_d;
      mem_dst      <= mem_dst_d;
      mem_regwrite <= mem_rw_d;
      wb_dst       <= wb_dst_d;
      wb_regwrite  <= wb_rw_d;
    end
  end

endmodule

// File: rtl/hcu_bypass_pick.sv
module hcu_bypass_pick
  import hcu_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] mem_dst,
  input  logic              mem_regwrite,
  input  logic [ADDR_W-1:0] wb_dst,
  input  logic              wb_regwrite,
  output fwd_sel_e          sel
);

  logic mem_hit, wb_hit;

  assign mem_hit = mem_regwrite && (mem_dst != '0) && (mem_dst == src);
  assign wb_hit  = wb_regwrite  && (wb_dst  != '0) && (wb_dst  == src);

  always_comb begin
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

endmodule

// File: rtl/hcu_load_use.sv
module hcu_load_use #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              ex_memread,
  input  logic [ADDR_W-1:0] ex_dst,
  input  logic [ADDR_W-1:0] id_rs,
  input  logic [ADDR_W-1:0] id_rt,
  output logic              stall
);

  logic dst_live, src_hit;

  assign dst_live = ex_memread && (ex_dst != '0);
  assign src_hit  = (ex_dst == id_rs) || (ex_dst == id_rt);
  assign stall    = dst_live && src_hit;

endmodule

// File: rtl/hazard_ctrl_unit.sv
module hazard_ctrl_unit
  import hcu_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] id_rs,
  input  logic [ADDR_W-1:0] id_rt,
  input  logic [ADDR_W-1:0] id_dst,
  input  logic              id_regwrite,
  input  logic              id_memread,
  input  logic              id_branch,
  input  logic              id_br_equal,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              idex_bubble,
  output logic              if_flush
);

  localparam int unsigned NOPND = HCU_NUM_OPND;

  logic [ADDR_W-1:0] ex_rs, ex_rt, ex_dst, mem_dst, wb_dst;
  logic              ex_regwrite, ex_memread, mem_regwrite, wb_regwrite;
  logic              stall;
  logic [ADDR_W-1:0] opnd_src [NOPND];
  fwd_sel_e          opnd_sel [NOPND];

  hcu_stage_track #(.ADDR_W(ADDR_W)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_rs        (id_rs),
    .id_rt        (id_rt),
    .id_dst       (id_dst),
    .id_regwrite  (id_regwrite),
    .id_memread   (id_memread),
    .insert_bubble(stall),
    .ex_rs        (ex_rs),
    .ex_rt        (ex_rt),
    .ex_dst       (ex_dst),
    .ex_regwrite  (ex_regwrite),
    .ex_memread   (ex_memread),
    .mem_dst      (mem_dst),
    .mem_regwrite (mem_regwrite),
    .wb_dst       (wb_dst),
    .wb_regwrite  (wb_regwrite)
  );

  assign opnd_src[0] = ex_rs;
  assign opnd_src[1] = ex_rt;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    hcu_bypass_pick #(.ADDR_W(ADDR_W)) u_pick (
      .src         (opnd_src[g]),
      .mem_dst     (mem_dst),
      .mem_regwrite(mem_regwrite),
      .wb_dst      (wb_dst),
      .wb_regwrite (wb_regwrite),
      .sel         (opnd_sel[g])
    );
  end

  hcu_load_use #(.ADDR_W(ADDR_W)) u_lu (
    .ex_memread(ex_memread),
    .ex_dst    (ex_dst),
    .id_rs     (id_rs),
    .id_rt     (id_rt),
    .stall     (stall)
  );

  // execute-stage write bit is not a hazard source here: results come from the latches behind it
  logic unused_ok;
  assign unused_ok = ex_regwrite;

  assign fwd_a       = opnd_sel[0];
  assign fwd_b       = opnd_sel[1];
  assign pc_we       = !stall;
  assign ifid_we     = !stall;
  assign idex_bubble = stall;
  // a held branch may compare stale operands, so the stall wins over the flush
  assign if_flush    = id_branch && id_br_equal && !stall;

endmodule

// File: rtl/hazard_ctrl_unit_chk.sv
module hazard_ctrl_unit_chk #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] id_dst,
  input logic              id_regwrite,
  input logic              id_memread,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b,
  input logic              idex_bubble
);

  assert_fwd_a_mem_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == 2'b10) |-> ($past(id_regwrite, 2) && ($past(id_dst, 2) != '0)));

  assert_fwd_b_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b == 2'b10) |-> ($past(id_regwrite, 2) && ($past(id_dst, 2) != '0)));

  assert_fwd_b_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b == 2'b01) |-> $past(id_regwrite, 3));

  assert_stall_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> $past(id_memread));

  assert_single_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> !idex_bubble);

endmodule

bind hazard_ctrl_unit hazard_ctrl_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .id_dst     (id_dst),
  .id_regwrite(id_regwrite),
  .id_memread (id_memread),
  .fwd_a      (fwd_a),
  .fwd_b      (fwd_b),
  .idex_bubble(idex_bubble)
);

// File: tb/tb_hazard_ctrl_unit.sv
module tb_hazard_ctrl_unit;

  localparam int AW = 5;

  logic          clk, rst_n;
  logic [AW-1:0] id_rs, id_rt, id_dst;
  logic          id_regwrite, id_memread, id_branch, id_br_equal;
  logic [1:0]    fwd_a, fwd_b;
  logic          pc_we, ifid_we, idex_bubble, if_flush;

  hazard_ctrl_unit #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt), .id_dst(id_dst),
    .id_regwrite(id_regwrite), .id_memread(id_memread), .id_branch(id_branch),
    .id_br_equal(id_br_equal), .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_we(pc_we),
    .ifid_we(ifid_we), .idex_bubble(idex_bubble), .if_flush(if_flush)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic [1:0] fa, fb;
    logic       pcwe, ifidwe, bub, fl;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0;
  bit   done = 0;

  // bench model of the execute, memory and write-back latch contents
  logic [AW-1:0] m_ex_rs, m_ex_rt, m_ex_dst, m_mem_dst, m_wb_dst;
  logic          m_ex_rw, m_ex_mr, m_mem_rw, m_wb_rw;

  function automatic logic [1:0] pick(input logic [AW-1:0] s);
    if (m_mem_rw && m_mem_dst != 0 && m_mem_dst == s) return 2'b10;
    if (m_wb_rw && m_wb_dst != 0 && m_wb_dst == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic model_clear();
    m_ex_rs = 0; m_ex_rt = 0; m_ex_dst = 0; m_ex_rw = 0; m_ex_mr = 0;
    m_mem_dst = 0; m_mem_rw = 0; m_wb_dst = 0; m_wb_rw = 0;
  endtask

  task automatic drive(input logic [AW-1:0] rs, rt, dst, input logic rw, mr, br, eq);
    id_rs = rs; id_rt = rt; id_dst = dst;
    id_regwrite = rw; id_memread = mr; id_branch = br; id_br_equal = eq;
  endtask

  // one decode instruction; repeated while the model predicts a load-use hold
  task automatic issue(input logic [AW-1:0] rs, rt, dst, input logic rw, mr, br, eq,
                       input string tag);
    logic stl;
    exp_t e;
    do begin
      @(negedge clk);
      drive(rs, rt, dst, rw, mr, br, eq);
      stl = m_ex_mr && (m_ex_dst != 0) && (m_ex_dst == rs || m_ex_dst == rt);
      e.fa = pick(m_ex_rs); e.fb = pick(m_ex_rt);
      e.pcwe = !stl; e.ifidwe = !stl; e.bub = stl; e.fl = !stl && br && eq;
      e.tag = tag;
      q.push_back(e);
      m_wb_dst = m_mem_dst; m_wb_rw = m_mem_rw;
      m_mem_dst = m_ex_dst; m_mem_rw = m_ex_rw;
      if (stl) begin
        m_ex_rs = 0; m_ex_rt = 0; m_ex_dst = 0; m_ex_rw = 0; m_ex_mr = 0;
      end else begin
        m_ex_rs = rs; m_ex_rt = rt; m_ex_dst = dst; m_ex_rw = rw; m_ex_mr = mr;
      end
    end while (stl);
  endtask

  task automatic nop(input string tag);
    issue(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor: pops expected items and compares once outputs have settled
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (fwd_a !== e.fa || fwd_b !== e.fb || pc_we !== e.pcwe ||
            ifid_we !== e.ifidwe || idex_bubble !== e.bub || if_flush !== e.fl) begin
          bad++;
          $display("FAIL %s: actual fa=%b fb=%b pcwe=%b ifidwe=%b bub=%b fl=%b expected fa=%b fb=%b pcwe=%b ifidwe=%b bub=%b fl=%b",
                   e.tag, fwd_a, fwd_b, pc_we, ifid_we, idex_bubble, if_flush,
                   e.fa, e.fb, e.pcwe, e.ifidwe, e.bub, e.fl);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_t e;
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0);
    model_clear();
    repeat (2) @(negedge clk);
    // R11: reset state with idle decode
    e.fa = 2'b00; e.fb = 2'b00; e.pcwe = 1; e.ifidwe = 1; e.bub = 0; e.fl = 0;
    e.tag = "R11 reset";
    q.push_back(e);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1: EX/MEM bypass on operand A
    issue(0, 0, 1, 1, 0, 0, 0, "R1 producer");
    issue(1, 2, 6, 1, 0, 0, 0, "R1 consumer decode");
    nop("R1 consumer in EX, A=10");
    nop("R1 drain"); nop("R1 drain");

    // R2: EX/MEM bypass on operand B, R3: MEM/WB on operand B
    issue(0, 0, 2, 1, 0, 0, 0, "R2 producer");
    issue(7, 2, 8, 1, 0, 0, 0, "R2 consumer");
    nop("R2 B=10");
    issue(0, 0, 3, 1, 0, 0, 0, "R3 producer");
    nop("R3 gap");
    issue(9, 3, 10, 1, 0, 0, 0, "R3 consumer");
    nop("R3 B=01");
    nop("R3 drain");

    // R4: both latches match -> EX/MEM wins
    issue(0, 0, 4, 1, 0, 0, 0, "R4 older");
    issue(0, 0, 4, 1, 0, 0, 0, "R4 newer");
    issue(4, 4, 11, 1, 0, 0, 0, "R4 consumer");
    nop("R4 A=B=10");
    nop("R4 drain"); nop("R4 drain");

    // R5: register 0 and write bit clear give no bypass
    issue(0, 0, 0, 1, 0, 0, 0, "R5 writes r0");
    issue(0, 0, 12, 0, 0, 0, 0, "R5 no write to r12");
    issue(0, 12, 13, 1, 0, 0, 0, "R5 consumer");
    nop("R5 A=B=00");
    nop("R5 drain"); nop("R5 drain");

    // R6/R7: load-use on rs, one stall, then MEM/WB bypass
    issue(0, 0, 5, 1, 1, 0, 0, "R6 load r5");
    issue(5, 0, 14, 1, 0, 0, 0, "R6 dependent rs stalls");
    nop("R7 held instr in EX after load, A=01");
    nop("R7 drain"); nop("R7 drain");

    // R6: load-use via rt; load to r0 and independent follower do not stall
    issue(0, 0, 15, 1, 1, 0, 0, "R6 load r15");
    issue(16, 15, 17, 1, 0, 0, 0, "R6 dependent rt stalls");
    nop("R7 B=01"); nop("R6 drain"); nop("R6 drain");
    issue(0, 0, 0, 1, 1, 0, 0, "R6 load r0");
    issue(0, 0, 18, 1, 0, 0, 0, "R6 r0 load no stall");
    issue(0, 0, 19, 1, 1, 0, 0, "R6 load r19");
    issue(20, 21, 22, 1, 0, 0, 0, "R6 independent no stall");
    nop("R6 drain"); nop("R6 drain"); nop("R6 drain");

    // R8: taken and untaken branches
    issue(1, 2, 0, 0, 0, 1, 1, "R8 taken flush");
    nop("R8 flushed slot");
    issue(1, 2, 0, 0, 0, 1, 0, "R8 untaken no flush");
    nop("R8 drain"); nop("R8 drain");

    // R9: branch depending on a load: no flush in stall cycle, flush after
    issue(0, 0, 23, 1, 1, 0, 0, "R9 load r23");
    issue(23, 1, 0, 0, 0, 1, 1, "R9 branch stall then flush");
    nop("R9 flushed slot");
    nop("R9 drain"); nop("R9 drain");

    // R10: distance of three needs no bypass
    issue(0, 0, 24, 1, 0, 0, 0, "R10 producer");
    nop("R10 gap"); nop("R10 gap");
    issue(24, 24, 25, 1, 0, 0, 0, "R10 consumer");
    nop("R10 A=B=00");

    @(negedge clk); #4;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule